// File: doc/BRIEF.md
# I2C Target with Host Service Flags

This block is the target (slave) side of a two-wire I2C bus using 7-bit addressing. It watches the bus for START and STOP, takes in the address byte, and answers only when the seven address bits match its own address. The direction bit then chooses one of two paths. Either the block collects bytes from the bus controller, or it sends bytes that the host supplies through a one-byte data register.

Two request flags tell the host what to do. `rreq_o` means a received byte is waiting to be taken. `treq_o` means the block needs a byte to send. While either flag is set, the block holds SCL low, so the bus waits for the host. A take strobe or a load strobe from the host clears the flag and lets the clock go.

Three interrupt causes have their own raw status bits: data, START seen and STOP seen. Each bit has its own mask and its own write-1 clear, and the masked causes are combined into one interrupt line. Both bus inputs pass through a synchroniser before any edge is decoded.

Top module: `i2c_target`

## Requirements
- R1: A falling SDA while SCL is high sets raw bit 1 (start). A rising SDA while SCL is high sets raw bit 2 (stop).
- R2: After START, the block samples 8 bits MSB first on rising SCL: 7 address bits, then a direction bit (1 means the block transmits). On an address match it pulls SDA low for the acknowledge clock.
- R3: On an address mismatch, SDA stays released in the acknowledge clock. No request flag rises and the bus is ignored until the next START.
- R4: In receive direction, after each 8th data bit `rx_byte_o` holds the byte (MSB first), `rreq_o` is 1, and SCL is held low.
- R5: A `rx_take_i` pulse while `rreq_o` is set clears `rreq_o`. The block then pulls SDA low to acknowledge and releases SCL one cycle later.
- R6: In transmit direction, after the address acknowledge `treq_o` is 1 and SCL is held low. A `tx_load_i` pulse clears `treq_o`, releases SCL, and the loaded byte is then driven MSB first.
- R7: An acknowledge (SDA low) from the controller after a sent byte raises `treq_o` again with SCL held. A not-acknowledge makes the block leave SDA released and raise no further request until the next START.
- R8: Raw bits set on their events whatever the mask. Bit 0 = data (set when `rreq_o` or `treq_o` rises). `irq_o` is the OR of the raw bits ANDed with `irq_mask_i` in the same bit order.
- R9: A 1 in `irq_clr_i` clears the matching raw bit on the next clock.
- R10: After reset both line pulls are off, both flags are 0, and the raw status and `irq_o` are 0.
- R11: A repeated START in the middle of a transfer returns the block to address reception. A new address with either direction is then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (open drain) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| own_addr_i | input | 7 | Address this target answers to |
| rx_byte_o | output | 8 | Last byte received |
| rx_take_i | input | 1 | Host read strobe for the received byte |
| tx_byte_i | input | 8 | Byte to send |
| tx_load_i | input | 1 | Host write strobe for the byte to send |
| rreq_o | output | 1 | Received byte awaits the host |
| treq_o | output | 1 | Byte to send is requested |
| irq_mask_i | input | 3 | Enable per cause: [0] data, [1] start, [2] stop |
| irq_clr_i | input | 3 | Write-1 clear per cause |
| irq_raw_o | output | 3 | Raw status per cause |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with `SYNC_STAGES = 3` and a bus half-period of 16 clocks. The deeper synchroniser moves every reaction of the block several cycles behind the SCL edge that causes it. That delay shows whether SDA changes stay inside the SCL low phase and whether a slow host service really stalls the controller model. The wired-AND line model lets the host service interleave with a clock the controller has already raised. This covers the stretch-then-release hand-over in both directions, a repeated START, and the NACK ending of a read.

// File: rtl/i2c_target_pkg.sv
`timescale 1ns/1ps
package i2c_target_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_END, ST_ADDR_ACK,
      ST_RX, ST_RX_END, ST_RX_WAIT, ST_RX_ACK,
      ST_TX_WAIT, ST_TX, ST_TX_ACK, ST_TX_ACK_END
   } tgt_state_e;
   localparam int IRQ_DATA  = 0;
   localparam int IRQ_START = 1;
   localparam int IRQ_STOP  = 2;
   localparam int IRQ_N     = 3;
   localparam int ADDR_W    = 7;
   localparam int BYTE_W    = 8;
endpackage

// File: rtl/i2c_target_sync.sv
`timescale 1ns/1ps
module i2c_target_sync #(
   parameter int STAGES = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("i2c_target_sync: STAGES must be 2..4");
      end
   endgenerate

   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {STAGES{IDLE_VAL}};
      else         ff_q <= {ff_q[STAGES-2:0], d_i};
   end

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_target_linemon.sv
`timescale 1ns/1ps
module i2c_target_linemon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s_o,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   localparam int LINES = 2;
   logic [LINES-1:0] raw_in, syn;
   logic scl_prev_q, sda_prev_q;

   assign raw_in = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         i2c_target_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .d_i   (raw_in[g]),
            .q_o   (syn[g])
         );
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
      end else begin
         scl_prev_q <= syn[0];
         sda_prev_q <= syn[1];
      end
   end

   assign scl_s_o    = syn[0];
   assign sda_s_o    = syn[1];
   assign scl_rise_o = !scl_prev_q && syn[0];
   assign scl_fall_o = scl_prev_q && !syn[0];
   assign start_o    = scl_prev_q && syn[0] && sda_prev_q && !syn[1];
   assign stop_o     = scl_prev_q && syn[0] && !sda_prev_q && syn[1];
endmodule

// File: rtl/i2c_target_engine.sv
`timescale 1ns/1ps
module i2c_target_engine
   import i2c_target_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              scl_s_i,
   input  logic              sda_s_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              rx_take_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   input  logic              tx_load_i,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              rreq_o,
   output logic              treq_o,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   output logic              data_ev_o
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   tgt_state_e        st_q;
   logic [BYTE_W-1:0] sh_q, rxbuf_q;
   logic [CNT_W-1:0]  bit_q;
   logic              rreq_q, treq_q, sclp_q, sdap_q, dev_q;
   logic              in_wait;

   assign in_wait = (st_q == ST_RX_WAIT) || (st_q == ST_TX_WAIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         sh_q    <= '0;
         rxbuf_q <= '0;
         bit_q   <= '0;
         rreq_q  <= 1'b0;
         treq_q  <= 1'b0;
         sclp_q  <= 1'b0;
         sdap_q  <= 1'b0;
         dev_q   <= 1'b0;
      end else begin
         dev_q <= 1'b0;
         // clock is let go one cycle after the host service leaves a wait state
         if (sclp_q && !in_wait) sclp_q <= 1'b0;
         if (start_i) begin
            st_q   <= ST_ADDR;
            bit_q  <= '0;
            sdap_q <= 1'b0;
            rreq_q <= 1'b0;
            treq_q <= 1'b0;
         end else if (stop_i) begin
            st_q   <= ST_IDLE;
            sdap_q <= 1'b0;
            rreq_q <= 1'b0;
            treq_q <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADDR, ST_RX: if (scl_rise_i) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
                  bit_q <= bit_q + 1'b1;
                  if (bit_q == LAST_BIT)
                     st_q <= (st_q == ST_ADDR) ? ST_ADDR_END : ST_RX_END;
               end
               ST_ADDR_END: if (scl_fall_i) begin
                  if (sh_q[BYTE_W-1:1] == own_addr_i) begin
                     sdap_q <= 1'b1;
                     st_q   <= ST_ADDR_ACK;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
               ST_ADDR_ACK: if (scl_fall_i) begin
                  sdap_q <= 1'b0;
                  bit_q  <= '0;
                  if (sh_q[0]) begin
                     treq_q <= 1'b1;
                     sclp_q <= 1'b1;
                     dev_q  <= 1'b1;
                     st_q   <= ST_TX_WAIT;
                  end else begin
                     st_q <= ST_RX;
                  end
               end
               ST_RX_END: if (scl_fall_i) begin
                  rxbuf_q <= sh_q;
                  rreq_q  <= 1'b1;
                  sclp_q  <= 1'b1;
                  dev_q   <= 1'b1;
                  st_q    <= ST_RX_WAIT;
               end
               ST_RX_WAIT: if (rx_take_i) begin
                  rreq_q <= 1'b0;
                  sdap_q <= 1'b1;
                  st_q   <= ST_RX_ACK;
               end
               ST_RX_ACK: if (scl_fall_i) begin
                  sdap_q <= 1'b0;
                  bit_q  <= '0;
                  st_q   <= ST_RX;
               end
               ST_TX_WAIT: if (tx_load_i) begin
                  sh_q   <= tx_byte_i;
                  sdap_q <= !tx_byte_i[BYTE_W-1];
                  treq_q <= 1'b0;
                  bit_q  <= '0;
                  st_q   <= ST_TX;
               end
               ST_TX: if (scl_fall_i) begin
                  if (bit_q == LAST_BIT) begin
                     sdap_q <= 1'b0;
                     st_q   <= ST_TX_ACK;
                  end else begin
                     sdap_q <= !sh_q[BYTE_W-2];
                     sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                     bit_q  <= bit_q + 1'b1;
                  end
               end
               ST_TX_ACK: if (scl_rise_i) begin
                  st_q <= sda_s_i ? ST_IDLE : ST_TX_ACK_END;
               end
               ST_TX_ACK_END: if (scl_fall_i) begin
                  treq_q <= 1'b1;
                  sclp_q <= 1'b1;
                  dev_q  <= 1'b1;
                  st_q   <= ST_TX_WAIT;
               end
               default: ;
            endcase
         end
      end
   end

   assign rx_byte_o  = rxbuf_q;
   assign rreq_o     = rreq_q;
   assign treq_o     = treq_q;
   assign scl_pull_o = sclp_q;
   assign sda_pull_o = sdap_q;
   assign data_ev_o  = dev_q;

   // R4
   stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rreq_q || treq_q) |-> sclp_q);

   // R2
   sda_in_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sdap_q) |-> !scl_s_i);

   // R3
   mismatch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_ADDR_END && scl_fall_i && sh_q[BYTE_W-1:1] != own_addr_i
       && !start_i && !stop_i) |=> (!sdap_q && st_q == ST_IDLE));

   // R7
   nack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_TX_ACK && scl_rise_i && sda_s_i && !start_i && !stop_i)
      |=> (!sdap_q && !treq_q && st_q == ST_IDLE));

   // R11
   restart_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (st_q == ST_ADDR && !rreq_q && !treq_q));
endmodule

// File: rtl/i2c_target_irq.sv
`timescale 1ns/1ps
module i2c_target_irq #(
   parameter int N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] raw_o,
   output logic         irq_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("i2c_target_irq: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] raw_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_cause
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       raw_q[i] <= 1'b0;
            else if (set_i[i]) raw_q[i] <= 1'b1;
            else if (clr_i[i]) raw_q[i] <= 1'b0;
         end

         // R9
         clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[i] && !set_i[i]) |=> !raw_q[i]);

         // R8
         raw_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[i] |=> raw_q[i]);
      end
   endgenerate

   assign raw_o = raw_q;
   assign irq_o = |(raw_q & mask_i);
endmodule

// File: rtl/i2c_target.sv
`timescale 1ns/1ps
module i2c_target
   import i2c_target_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   input  logic [ADDR_W-1:0] own_addr_i,
   output logic [BYTE_W-1:0] rx_byte_o,
   input  logic              rx_take_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   input  logic              tx_load_i,
   output logic              rreq_o,
   output logic              treq_o,
   input  logic [IRQ_N-1:0]  irq_mask_i,
   input  logic [IRQ_N-1:0]  irq_clr_i,
   output logic [IRQ_N-1:0]  irq_raw_o,
   output logic              irq_o
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, data_ev;
   logic [IRQ_N-1:0] irq_set;

   i2c_target_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_linemon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s_o   (scl_s),
      .sda_s_o   (sda_s),
      .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall),
      .start_o   (start_det),
      .stop_o    (stop_det)
   );

   i2c_target_engine u_engine (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .scl_s_i   (scl_s),
      .sda_s_i   (sda_s),
      .scl_rise_i(scl_rise),
      .scl_fall_i(scl_fall),
      .start_i   (start_det),
      .stop_i    (stop_det),
      .own_addr_i(own_addr_i),
      .rx_take_i (rx_take_i),
      .tx_byte_i (tx_byte_i),
      .tx_load_i (tx_load_i),
      .rx_byte_o (rx_byte_o),
      .rreq_o    (rreq_o),
      .treq_o    (treq_o),
      .scl_pull_o(scl_pull_o),
      .sda_pull_o(sda_pull_o),
      .data_ev_o (data_ev)
   );

   always_comb begin
      irq_set            = '0;
      irq_set[IRQ_DATA]  = data_ev;
      irq_set[IRQ_START] = start_det;
      irq_set[IRQ_STOP]  = stop_det;
   end

   i2c_target_irq #(.N(IRQ_N)) u_irq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (irq_set),
      .clr_i (irq_clr_i),
      .mask_i(irq_mask_i),
      .raw_o (irq_raw_o),
      .irq_o (irq_o)
   );
endmodule

// File: tb/i2c_target_tb_top.sv
`timescale 1ns/1ps
module i2c_target_tb_top;
   localparam int H = 16;
   localparam logic [6:0] OWN = 7'h3B;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, m_scl, m_sda;
   logic scl_pull, sda_pull, rx_take, tx_load, rreq, treq, irq;
   logic [7:0] rx_byte, tx_byte;
   logic [2:0] irq_mask, irq_clr, irq_raw;
   wire scl_line = m_scl & ~scl_pull;
   wire sda_line = m_sda & ~sda_pull;

   int checks = 0, fails = 0, rreq_seen = 0, treq_seen = 0;
   logic [7:0] rx_q[$];
   logic [7:0] tx_q[$];

   i2c_target #(.SYNC_STAGES(3)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .own_addr_i(OWN),
      .rx_byte_o(rx_byte), .rx_take_i(rx_take), .tx_byte_i(tx_byte),
      .tx_load_i(tx_load), .rreq_o(rreq), .treq_o(treq),
      .irq_mask_i(irq_mask), .irq_clr_i(irq_clr), .irq_raw_o(irq_raw), .irq_o(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scl_high();
      m_scl = 1'b1;
      while (!scl_line) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; cyc(H);
      scl_high(); cyc(H);
      m_sda = 1'b0; cyc(H);
      m_scl = 1'b0; cyc(4);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; cyc(H);
      scl_high(); cyc(H);
      m_sda = 1'b1; cyc(H);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; cyc(H);
      scl_high(); cyc(H);
      m_scl = 1'b0; cyc(4);
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; cyc(H);
      scl_high(); cyc(H/2);
      b = sda_line; cyc(H/2);
      m_scl = 1'b0; cyc(4);
   endtask

   task automatic put_byte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(ack);
   endtask

   task automatic get_byte(output logic [7:0] d, input logic nack);
      for (int i = 7; i >= 0; i--) get_bit(d[i]);
      put_bit(nack);
   endtask

   task automatic clr_all();
      irq_clr = 3'b111; cyc(1);
      irq_clr = 3'b000; cyc(1);
   endtask

   // scoreboard monitor acting as the host
   initial begin
      rx_take = 1'b0; tx_load = 1'b0; tx_byte = '0;
      forever begin
         @(negedge clk);
         if (rreq) begin
            logic [7:0] e;
            rreq_seen++;
            cyc(24);
            chk(scl_line == 1'b0, "R4 SCL held while byte waits", int'(scl_line), 0);
            if (rx_q.size() == 0) begin
               chk(1'b0, "R4 unexpected received byte", int'(rx_byte), 0);
               e = rx_byte;
            end else e = rx_q.pop_front();
            chk(rx_byte == e, "R4 received byte", int'(rx_byte), int'(e));
            rx_take = 1'b1; @(negedge clk);
            rx_take = 1'b0; @(negedge clk);
            chk(!rreq, "R5 take clears rreq", int'(rreq), 0);
         end else if (treq) begin
            treq_seen++;
            cyc(24);
            chk(scl_line == 1'b0, "R6 SCL held while byte requested", int'(scl_line), 0);
            if (tx_q.size() == 0) begin
               chk(1'b0, "R6 unexpected transmit request", 1, 0);
               tx_byte = 8'hFF;
            end else tx_byte = tx_q.pop_front();
            tx_load = 1'b1; @(negedge clk);
            tx_load = 1'b0; @(negedge clk);
            chk(!treq, "R6 load clears treq", int'(treq), 0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] d;
      int n;
      rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
      irq_mask = 3'b000; irq_clr = 3'b000;
      cyc(10);
      rst_n = 1'b1;
      cyc(5);
      // R10
      chk(!scl_pull && !sda_pull, "R10 lines released", int'({scl_pull, sda_pull}), 0);
      chk(!rreq && !treq, "R10 flags clear", int'({rreq, treq}), 0);
      chk(irq_raw == 3'b000 && !irq, "R10 no interrupt", int'({irq, irq_raw}), 0);

      // write transfer
      irq_mask = 3'b111;
      bus_start();
      chk(irq_raw[1], "R1 start raw bit", int'(irq_raw), 2);
      chk(irq, "R8 start interrupt", int'(irq), 1);
      irq_clr = 3'b010; cyc(1); irq_clr = 3'b000; cyc(1);
      chk(irq_raw == 3'b000, "R9 start cleared", int'(irq_raw), 0);
      chk(!irq, "R8 nothing pending", int'(irq), 0);
      rx_q.push_back(8'hA5); rx_q.push_back(8'h3C);
      put_byte({OWN, 1'b0}, a);
      chk(a == 1'b0, "R2 address acknowledged", int'(a), 0);
      put_byte(8'hA5, a);
      chk(a == 1'b0, "R5 byte acknowledged", int'(a), 0);
      put_byte(8'h3C, a);
      chk(a == 1'b0, "R5 second byte acknowledged", int'(a), 0);
      chk(irq_raw[0], "R8 data raw bit", int'(irq_raw), 1);
      irq_mask = 3'b110; cyc(2);
      chk(!irq, "R8 data masked", int'(irq), 0);
      irq_clr = 3'b001; cyc(1); irq_clr = 3'b000; cyc(1);
      chk(!irq_raw[0], "R9 data cleared", int'(irq_raw), 0);
      bus_stop();
      chk(irq_raw[2], "R1 stop raw bit", int'(irq_raw), 4);
      chk(irq, "R8 stop interrupt", int'(irq), 1);
      clr_all();
      chk(rx_q.size() == 0, "R4 all bytes delivered", rx_q.size(), 0);

      // address mismatch
      n = rreq_seen;
      bus_start();
      put_byte({7'h12, 1'b0}, a);
      chk(a == 1'b1, "R3 no acknowledge on mismatch", int'(a), 1);
      put_byte(8'h77, a);
      chk(a == 1'b1, "R3 bus ignored after mismatch", int'(a), 1);
      chk(rreq_seen == n && !scl_pull, "R3 no request raised", rreq_seen - n, 0);
      bus_stop();
      clr_all();

      // read transfer ended by NACK
      irq_mask = 3'b111;
      tx_q.push_back(8'h96); tx_q.push_back(8'h5A);
      bus_start();
      put_byte({OWN, 1'b1}, a);
      chk(a == 1'b0, "R2 read address acknowledged", int'(a), 0);
      get_byte(d, 1'b0);
      chk(d == 8'h96, "R6 first byte sent MSB first", int'(d), 'h96);
      get_byte(d, 1'b1);
      chk(d == 8'h5A, "R7 byte after controller ack", int'(d), 'h5A);
      n = treq_seen;
      cyc(40);
      chk(!treq && treq_seen == n, "R7 no request after NACK", treq_seen - n, 0);
      chk(!sda_pull && !scl_pull, "R7 lines released after NACK", int'({scl_pull, sda_pull}), 0);
      bus_stop();
      clr_all();

      // repeated START switching direction
      rx_q.push_back(8'hC3); tx_q.push_back(8'h1E);
      bus_start();
      put_byte({OWN, 1'b0}, a);
      put_byte(8'hC3, a);
      chk(a == 1'b0, "R11 byte before restart", int'(a), 0);
      clr_all();
      bus_start();
      chk(irq_raw[1], "R11 repeated start seen", int'(irq_raw), 2);
      put_byte({OWN, 1'b1}, a);
      chk(a == 1'b0, "R11 address after restart", int'(a), 0);
      get_byte(d, 1'b1);
      chk(d == 8'h1E, "R11 byte read after restart", int'(d), 'h1E);
      bus_stop();
      cyc(10);
      chk(rx_q.size() == 0 && tx_q.size() == 0, "R6 scoreboard drained",
          rx_q.size() + tx_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule